// File: doc/BRIEF.md
# Split-Mode Translation Lookaside Buffer

This block caches virtual-to-physical page translations for a two-level paged memory system. It keeps two independent direct-mapped arrays, one for user-mode and one for supervisor-mode translations. A lookup presents a virtual page number, a mode select and a write flag. In the same cycle the block returns a hit indication, the physical frame number and the page attributes: read-only, cache-inhibit and modified.

On a miss, an external table walker fetches the entry and writes it back through the refill port. Four invalidation strobes are available:
- flush both arrays;
- flush only the user array;
- flush only the supervisor array;
- purge the translation for one virtual page from both arrays at once.

The table walk, the decoding of control registers and any caches lie outside this block.

Top module: `tlb_split`

## Requirements
- R1: User and supervisor translations live in separate arrays. A refill with fillSuper=0 is visible only to lookups with lkSuper=0. A refill with fillSuper=1 is visible only to lookups with lkSuper=1.
- R2: A cycle with invAll=1 clears every entry of both arrays. From the next cycle, every lookup misses.
- R3: A cycle with invUser=1 clears every user entry and leaves supervisor entries valid.
- R4: A cycle with invSuper=1 clears every supervisor entry and leaves user entries valid.
- R5: A cycle with invPage=1 clears the entry for virtual page invVpn in both arrays. An entry that holds a different page at the same index stays valid, and so do entries at other indices.
- R6: A lookup is combinational. On a hit it returns, in the same cycle, the frame, readOnly, noCache and modified values of the last refill for that page and mode. On a miss, lkPfn, lkReadOnly, lkNoCache and lkModified are all 0.
- R7: A lookup with lkWrite=1 reports a miss when the cached entry has modified=0. A lookup with lkWrite=1 hits when modified=1. A lookup with lkWrite=0 hits regardless of modified. A read-only entry still hits and reports lkReadOnly=1.
- R8: When a refill and any invalidate strobe occur in the same cycle, the invalidate takes effect and the refill is discarded.
- R9: The arrays are direct-mapped and indexed by the low log2(DEPTH) bits of the virtual page number. A refill replaces any entry at the same index and mode, so the previously cached page then misses.
- R10: After reset, every entry in both arrays is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lkVpn | input | VPN_W | Lookup virtual page number |
| lkSuper | input | 1 | Lookup mode: 1 supervisor, 0 user |
| lkWrite | input | 1 | Lookup is for a write access |
| lkHit | output | 1 | Translation found and usable |
| lkPfn | output | PFN_W | Physical frame number (0 on miss) |
| lkReadOnly | output | 1 | Page is read-only (0 on miss) |
| lkNoCache | output | 1 | Page must not be cached (0 on miss) |
| lkModified | output | 1 | Page modified flag (0 on miss) |
| fillValid | input | 1 | Refill strobe from the table walker |
| fillSuper | input | 1 | Refill target array: 1 supervisor, 0 user |
| fillVpn | input | VPN_W | Refill virtual page number |
| fillPfn | input | PFN_W | Refill physical frame number |
| fillReadOnly | input | 1 | Refill read-only attribute |
| fillNoCache | input | 1 | Refill cache-inhibit attribute |
| fillModified | input | 1 | Refill modified flag |
| invAll | input | 1 | Invalidate both arrays |
| invUser | input | 1 | Invalidate the user array |
| invSuper | input | 1 | Invalidate the supervisor array |
| invPage | input | 1 | Purge one virtual page in both arrays |
| invVpn | input | VPN_W | Virtual page number to purge |

## Verification
The assertions check the following on every cycle:
- after any flush or purge, a lookup in the affected mode, or of the purged page, misses in the next cycle;
- a clean refill is returned on the next read lookup of that page;
- a miss never leaks frame or attribute bits;
- a write hit always reports the modified flag set.

Some behaviour needs a chosen sequence, and only the bench scenarios can show it:
- that a flush of one mode leaves the other mode intact;
- that a purge spares a different page sharing the index;
- that a direct-mapped conflict evicts the older page;
- that a refill colliding with an unrelated invalidate is dropped.

// File: rtl/tlb_split_pkg.sv
package tlb_split_pkg;

  // Array select: 0 = user, 1 = supervisor
  localparam int MODE_USER  = 0;
  localparam int MODE_SUPER = 1;
  localparam int NUM_MODES  = 2;

  typedef struct packed {
    logic readOnly;
    logic noCache;
    logic modified;
  } tlbAttr_t;

  // Strobes from control to datapath, one bit per mode where relevant
  typedef struct packed {
    logic [NUM_MODES-1:0] clr;
    logic                 purge;
    logic [NUM_MODES-1:0] wr;
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_split_pkg::*;
(
  input  logic       fillValid,
  input  logic       fillSuper,
  input  logic       invAll,
  input  logic       invUser,
  input  logic       invSuper,
  input  logic       invPage,
  output tlbStrobe_t strobe
);

  logic anyInv;

  always_comb begin
    anyInv = invAll | invUser | invSuper | invPage;
    strobe = '0;
    strobe.clr[MODE_USER]  = invAll | invUser;
    strobe.clr[MODE_SUPER] = invAll | invSuper;
    strobe.purge           = invPage;
    // invalidation wins: a colliding refill is dropped
    if (fillValid && !anyInv) begin
      strobe.wr[MODE_SUPER] = fillSuper;
      strobe.wr[MODE_USER]  = ~fillSuper;
    end
  end

endmodule

// File: rtl/tlb_bank.sv
module tlb_bank
  import tlb_split_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             purge,
  input  logic [VPN_W-1:0] purgeVpn,
  input  logic             wr,
  input  logic [VPN_W-1:0] wrVpn,
  input  logic [PFN_W-1:0] wrPfn,
  input  tlbAttr_t         wrAttr,
  input  logic [VPN_W-1:0] rdVpn,
  output logic             rdHit,
  output logic [PFN_W-1:0] rdPfn,
  output tlbAttr_t         rdAttr
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int TAG_W = VPN_W - IDX_W;

  logic [DEPTH-1:0] validQ;
  logic [TAG_W-1:0] tagMem  [DEPTH];
  logic [PFN_W-1:0] pfnMem  [DEPTH];
  tlbAttr_t         attrMem [DEPTH];

  logic [IDX_W-1:0] rdIdx, wrIdx, pgIdx;
  logic [TAG_W-1:0] rdTag, wrTag, pgTag;
  logic             pgMatch;

  assign rdIdx = rdVpn[IDX_W-1:0];
  assign rdTag = rdVpn[VPN_W-1:IDX_W];
  assign wrIdx = wrVpn[IDX_W-1:0];
  assign wrTag = wrVpn[VPN_W-1:IDX_W];
  assign pgIdx = purgeVpn[IDX_W-1:0];
  assign pgTag = purgeVpn[VPN_W-1:IDX_W];

  assign pgMatch = validQ[pgIdx] && (tagMem[pgIdx] == pgTag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (clr) begin
      validQ <= '0;
    end else begin
      if (purge && pgMatch) validQ[pgIdx] <= 1'b0;
      if (wr)               validQ[wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) begin
      tagMem[wrIdx]  <= wrTag;
      pfnMem[wrIdx]  <= wrPfn;
      attrMem[wrIdx] <= wrAttr;
    end
  end

  assign rdHit  = validQ[rdIdx] && (tagMem[rdIdx] == rdTag);
  assign rdPfn  = pfnMem[rdIdx];
  assign rdAttr = attrMem[rdIdx];

endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_split_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobe_t       strobe,
  input  logic [VPN_W-1:0] lkVpn,
  input  logic             lkSuper,
  input  logic             lkWrite,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PFN_W-1:0] fillPfn,
  input  tlbAttr_t         fillAttr,
  input  logic [VPN_W-1:0] invVpn,
  output logic             lkHit,
  output logic [PFN_W-1:0] lkPfn,
  output tlbAttr_t         lkAttr
);

  logic [NUM_MODES-1:0] bankHit;
  logic [PFN_W-1:0]     bankPfn  [NUM_MODES];
  tlbAttr_t             bankAttr [NUM_MODES];

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_bank
    tlb_bank #(
      .VPN_W(VPN_W),
      .PFN_W(PFN_W),
      .DEPTH(DEPTH)
    ) u_bank (
      .clk      (clk),
      .rstN     (rstN),
      .clr      (strobe.clr[m]),
      .purge    (strobe.purge),
      .purgeVpn (invVpn),
      .wr       (strobe.wr[m]),
      .wrVpn    (fillVpn),
      .wrPfn    (fillPfn),
      .wrAttr   (fillAttr),
      .rdVpn    (lkVpn),
      .rdHit    (bankHit[m]),
      .rdPfn    (bankPfn[m]),
      .rdAttr   (bankAttr[m])
    );
  end

  logic             selHit;
  logic [PFN_W-1:0] selPfn;
  tlbAttr_t         selAttr;

  always_comb begin
    selHit  = bankHit[lkSuper];
    selPfn  = bankPfn[lkSuper];
    selAttr = bankAttr[lkSuper];
    // a write to a clean page goes to the walker to set the modify bit
    lkHit   = selHit && !(lkWrite && !selAttr.modified);
    lkPfn   = lkHit ? selPfn : '0;
    lkAttr  = lkHit ? selAttr : '0;
  end

endmodule

// File: rtl/tlb_split.sv
module tlb_split
  import tlb_split_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VPN_W-1:0] lkVpn,
  input  logic             lkSuper,
  input  logic             lkWrite,
  output logic             lkHit,
  output logic [PFN_W-1:0] lkPfn,
  output logic             lkReadOnly,
  output logic             lkNoCache,
  output logic             lkModified,
  input  logic             fillValid,
  input  logic             fillSuper,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PFN_W-1:0] fillPfn,
  input  logic             fillReadOnly,
  input  logic             fillNoCache,
  input  logic             fillModified,
  input  logic             invAll,
  input  logic             invUser,
  input  logic             invSuper,
  input  logic             invPage,
  input  logic [VPN_W-1:0] invVpn
);

  tlbStrobe_t strobe;
  tlbAttr_t   fillAttr, outAttr;

  assign fillAttr = '{readOnly: fillReadOnly, noCache: fillNoCache, modified: fillModified};

  tlb_ctrl u_ctrl (
    .fillValid (fillValid),
    .fillSuper (fillSuper),
    .invAll    (invAll),
    .invUser   (invUser),
    .invSuper  (invSuper),
    .invPage   (invPage),
    .strobe    (strobe)
  );

  tlb_datapath #(
    .VPN_W(VPN_W),
    .PFN_W(PFN_W),
    .DEPTH(DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .lkVpn    (lkVpn),
    .lkSuper  (lkSuper),
    .lkWrite  (lkWrite),
    .fillVpn  (fillVpn),
    .fillPfn  (fillPfn),
    .fillAttr (fillAttr),
    .invVpn   (invVpn),
    .lkHit    (lkHit),
    .lkPfn    (lkPfn),
    .lkAttr   (outAttr)
  );

  assign lkReadOnly = outAttr.readOnly;
  assign lkNoCache  = outAttr.noCache;
  assign lkModified = outAttr.modified;

endmodule

// File: rtl/tlb_split_chk.sv
module tlb_split_chk #(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int DEPTH = 1024
) (
  input logic             clk,
  input logic             rstN,
  input logic [VPN_W-1:0] lkVpn,
  input logic             lkSuper,
  input logic             lkWrite,
  input logic             lkHit,
  input logic [PFN_W-1:0] lkPfn,
  input logic             lkReadOnly,
  input logic             lkNoCache,
  input logic             lkModified,
  input logic             fillValid,
  input logic             fillSuper,
  input logic [VPN_W-1:0] fillVpn,
  input logic [PFN_W-1:0] fillPfn,
  input logic             invAll,
  input logic             invUser,
  input logic             invSuper,
  input logic             invPage,
  input logic [VPN_W-1:0] invVpn
);

  logic anyInv;
  assign anyInv = invAll | invUser | invSuper | invPage;

  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rstN)
    invAll |=> !lkHit); // R2

  AST_FLUSH_USER: assert property (@(posedge clk) disable iff (!rstN)
    invUser |=> (lkSuper || !lkHit)); // R3

  AST_FLUSH_SUPER: assert property (@(posedge clk) disable iff (!rstN)
    invSuper |=> (!lkSuper || !lkHit)); // R4

  AST_PAGE_PURGE: assert property (@(posedge clk) disable iff (!rstN)
    invPage |=> ((lkVpn != $past(invVpn)) || !lkHit)); // R5

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !anyInv) |=>
      ((lkVpn == $past(fillVpn) && lkSuper == $past(fillSuper) && !lkWrite)
        -> (lkHit && lkPfn == $past(fillPfn)))); // R6

  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> (lkPfn == '0 && !lkReadOnly && !lkNoCache && !lkModified)); // R6

  AST_WRITE_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    (lkHit && lkWrite) |-> lkModified); // R7

  AST_INV_OVER_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && invPage && fillVpn == invVpn) |=>
      ((lkVpn == $past(fillVpn) && lkSuper == $past(fillSuper)) -> !lkHit)); // R8

endmodule

bind tlb_split tlb_split_chk #(
  .VPN_W(VPN_W),
  .PFN_W(PFN_W),
  .DEPTH(DEPTH)
) u_chk (.*);

// File: tb/tlb_split_bench.sv
`timescale 1ns/1ps
module tlb_split_bench;

  localparam int VPN_W = 20;
  localparam int PFN_W = 20;
  localparam int DEPTH = 1024;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [VPN_W-1:0] lkVpn = '0;
  logic             lkSuper = 1'b0, lkWrite = 1'b0;
  logic             lkHit, lkReadOnly, lkNoCache, lkModified;
  logic [PFN_W-1:0] lkPfn;
  logic             fillValid = 1'b0, fillSuper = 1'b0;
  logic [VPN_W-1:0] fillVpn = '0;
  logic [PFN_W-1:0] fillPfn = '0;
  logic             fillReadOnly = 1'b0, fillNoCache = 1'b0, fillModified = 1'b0;
  logic             invAll = 1'b0, invUser = 1'b0, invSuper = 1'b0, invPage = 1'b0;
  logic [VPN_W-1:0] invVpn = '0;

  always #2 clk = ~clk;

  tlb_split #(.VPN_W(VPN_W), .PFN_W(PFN_W), .DEPTH(DEPTH)) u_tlb_split (.*);

  typedef struct {
    logic             hit;
    logic [PFN_W-1:0] pfn;
    logic             ro, nc, md;
    string            req;
  } expItem_t;

  expItem_t expQ[$];
  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;

  task automatic clearStrobes();
    fillValid = 0; invAll = 0; invUser = 0; invSuper = 0; invPage = 0;
  endtask

  task automatic step(input bit doFill, input bit fSup, input logic [VPN_W-1:0] fVpn,
                      input logic [PFN_W-1:0] fPfn, input bit fRo, input bit fNc, input bit fMd,
                      input bit iAll, input bit iUsr, input bit iSup, input bit iPg,
                      input logic [VPN_W-1:0] iVpn);
    @(posedge clk); #1;
    clearStrobes();
    fillValid = doFill; fillSuper = fSup; fillVpn = fVpn; fillPfn = fPfn;
    fillReadOnly = fRo; fillNoCache = fNc; fillModified = fMd;
    invAll = iAll; invUser = iUsr; invSuper = iSup; invPage = iPg; invVpn = iVpn;
  endtask

  task automatic fill(input bit sup, input logic [VPN_W-1:0] vpn, input logic [PFN_W-1:0] pfn,
                      input bit ro, input bit nc, input bit md);
    step(1, sup, vpn, pfn, ro, nc, md, 0, 0, 0, 0, '0);
  endtask

  task automatic inv(input bit a, input bit u, input bit s, input bit p, input logic [VPN_W-1:0] v);
    step(0, 0, '0, '0, 0, 0, 0, a, u, s, p, v);
  endtask

  task automatic look(input bit sup, input logic [VPN_W-1:0] vpn, input bit wr,
                      input bit eHit, input logic [PFN_W-1:0] ePfn,
                      input bit eRo, input bit eNc, input bit eMd, input string req);
    expItem_t it;
    @(posedge clk); #1;
    clearStrobes();
    lkSuper = sup; lkVpn = vpn; lkWrite = wr;
    it.hit = eHit; it.pfn = eHit ? ePfn : '0;
    it.ro = eHit & eRo; it.nc = eHit & eNc; it.md = eHit & eMd; it.req = req;
    expQ.push_back(it);
  endtask

  task automatic miss(input bit sup, input logic [VPN_W-1:0] vpn, input bit wr, input string req);
    look(sup, vpn, wr, 0, '0, 0, 0, 0, req);
  endtask

  // monitor: one expectation per cycle, sampled mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        total++;
        if (lkHit !== it.hit || lkPfn !== it.pfn || lkReadOnly !== it.ro ||
            lkNoCache !== it.nc || lkModified !== it.md) begin
          bad++;
          $display("FAIL %s: got hit=%b pfn=%h ro=%b nc=%b md=%b, expected hit=%b pfn=%h ro=%b nc=%b md=%b",
                   it.req, lkHit, lkPfn, lkReadOnly, lkNoCache, lkModified,
                   it.hit, it.pfn, it.ro, it.nc, it.md);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [VPN_W-1:0] VA = 20'h12345;  // index 0x345
  localparam logic [VPN_W-1:0] VB = 20'h56745;  // same index as VA, other tag
  localparam logic [VPN_W-1:0] VC = 20'h00010;
  localparam logic [VPN_W-1:0] VC2 = 20'h7F010; // same index as VC
  localparam logic [VPN_W-1:0] VD = 20'h0ABCD;

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R10 reset state
    miss(0, 20'h00123, 0, "R10 user after reset");
    miss(1, 20'h00123, 0, "R10 super after reset");

    // R6 / R1
    fill(0, VA, 20'hABCDE, 1, 0, 1);
    look(0, VA, 0, 1, 20'hABCDE, 1, 0, 1, "R6 user hit attrs");
    miss(1, VA, 0, "R1 super does not see user fill");
    fill(1, VA, 20'h11111, 0, 1, 0);
    look(1, VA, 0, 1, 20'h11111, 0, 1, 0, "R6 super hit attrs");
    look(0, VA, 0, 1, 20'hABCDE, 1, 0, 1, "R1 user entry unchanged");

    // R7 modify rule
    miss(1, VA, 1, "R7 write to clean page misses");
    look(0, VA, 1, 1, 20'hABCDE, 1, 0, 1, "R7 write to dirty read-only page hits");

    // R9 direct-mapped replacement
    fill(0, VB, 20'h22222, 0, 0, 1);
    miss(0, VA, 0, "R9 evicted page misses");
    look(0, VB, 0, 1, 20'h22222, 0, 0, 1, "R9 new page hits");
    fill(0, VA, 20'hABCDE, 1, 0, 1);

    // R5 single-page purge
    fill(0, VC, 20'h33333, 0, 0, 1);
    fill(1, VC, 20'h44444, 0, 0, 1);
    inv(0, 0, 0, 1, VC);
    miss(0, VC, 0, "R5 user page purged");
    miss(1, VC, 0, "R5 super page purged");
    look(0, VA, 0, 1, 20'hABCDE, 1, 0, 1, "R5 other user entry kept");
    look(1, VA, 0, 1, 20'h11111, 0, 1, 0, "R5 other super entry kept");
    fill(0, VC, 20'h33333, 0, 0, 1);
    inv(0, 0, 0, 1, VC2);
    look(0, VC, 0, 1, 20'h33333, 0, 0, 1, "R5 different tag same index kept");

    // R3 user flush
    inv(0, 1, 0, 0, '0);
    miss(0, VA, 0, "R3 user flushed A");
    miss(0, VC, 0, "R3 user flushed C");
    look(1, VA, 0, 1, 20'h11111, 0, 1, 0, "R3 super survives");

    // R4 super flush
    fill(0, VA, 20'h55555, 0, 1, 1);
    inv(0, 0, 1, 0, '0);
    miss(1, VA, 0, "R4 super flushed");
    look(0, VA, 0, 1, 20'h55555, 0, 1, 1, "R4 user survives");

    // R2 flush all
    fill(1, VA, 20'h66666, 1, 1, 1);
    inv(1, 0, 0, 0, '0);
    miss(0, VA, 0, "R2 user flushed");
    miss(1, VA, 0, "R2 super flushed");

    // R8 invalidate wins over refill
    step(1, 0, VD, 20'h77777, 0, 0, 1, 0, 0, 0, 1, 20'h00001);
    miss(0, VD, 0, "R8 fill dropped on page purge");
    step(1, 1, VD, 20'h88888, 0, 0, 1, 0, 1, 0, 0, '0);
    miss(1, VD, 0, "R8 fill dropped on user flush");
    fill(1, VD, 20'h88888, 0, 0, 1);
    look(1, VD, 0, 1, 20'h88888, 0, 0, 1, "R8 clean refill accepted");

    @(posedge clk); #1 clearStrobes();
    while (expQ.size() > 0) @(posedge clk);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule